// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms the data-memory address for every load and store of a small 8-bit microcontroller datapath. A 16-bit pointer is built from a pair of 8-bit general registers. One select bit chooses between two such pairs. The block then applies one of several address modes to that pointer:

- the pointer used as it stands;
- the pointer plus a short unsigned offset;
- the pointer moved down by one before the access;
- the pointer moved up by one after the access;
- a full 16-bit address taken straight from the instruction stream.

The two stepping modes also change the pointer itself. For these, the block returns the new pointer as separate high and low bytes, together with the register numbers that receive them and a write enable, so the register file can update both bytes in the same cycle as the access. The block has no state: every output follows its inputs combinationally.

Top module: `dag_top`

## Requirements
- R1: With mode code 0 (plain indirect) the effective address equals the selected 16-bit pointer, and no write-back is requested.
- R2: When `ptrSel` is 0 the pointer is {`yHi`,`yLo`}; when it is 1 the pointer is {`zHi`,`zLo`}. This holds in every pointer mode.
- R3: With mode code 1 (displacement) the effective address is the pointer plus the zero-extended 6-bit `dispOffset` (0 to 63), modulo 65536, and no write-back is requested.
- R4: With mode code 2 (pre-decrement) the effective address and the write-back value both equal the pointer minus one, modulo 65536, so 0x0000 becomes 0xFFFF.
- R5: With mode code 3 (post-increment) the effective address is the unmodified pointer, and the write-back value is the pointer plus one, modulo 65536, so 0xFFFF becomes 0x0000.
- R6: With mode code 4 (direct) the effective address equals `directAddr`, whatever the pointer and offset inputs hold, and no write-back is requested.
- R7: `wbEn` is 1 only for mode codes 2 and 3. While it is 0, `wbHi`, `wbLo`, `wbRegHi` and `wbRegLo` are all zero.
- R8: During a write-back, the high byte goes to register 29 and the low byte to register 28 when `ptrSel` is 0; they go to registers 31 and 30 when `ptrSel` is 1.
- R9: The unused mode codes 5, 6 and 7 give an effective address of 0x0000 and no write-back.
- R10: All outputs settle within the same cycle as an input change; there is no register between the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| modeCode | input | 3 | Address mode: 0 indirect, 1 displacement, 2 pre-decrement, 3 post-increment, 4 direct |
| ptrSel | input | 1 | Pointer pair select: 0 for registers 29:28, 1 for registers 31:30 |
| dispOffset | input | 6 | Unsigned displacement for mode 1 |
| directAddr | input | 16 | Address from the second instruction word for mode 4 |
| yHi | input | 8 | Contents of register 29 |
| yLo | input | 8 | Contents of register 28 |
| zHi | input | 8 | Contents of register 31 |
| zLo | input | 8 | Contents of register 30 |
| effAddr | output | 16 | Effective data-memory address |
| wbEn | output | 1 | Pointer write-back enable |
| wbHi | output | 8 | New high byte of the pointer |
| wbLo | output | 8 | New low byte of the pointer |
| wbRegHi | output | 5 | Register number that receives `wbHi` |
| wbRegLo | output | 5 | Register number that receives `wbLo` |

## Verification
The checker assumes that the mode code and all pointer inputs hold known, two-state values whenever it evaluates. It recomputes the expected address only from the port values, so it depends on no internal node. The stimulus keeps within that by driving every input from a task on the falling clock edge. It never leaves a port undriven, and it sweeps all eight mode codes, both pointer selects, and the offset extremes 0 and 63. The wrap cases at 0x0000 and 0xFFFF are applied on purpose, so that the modulo behaviour of the stepping modes and of the displacement sum is covered by both the checker and the bench.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [2:0] {
    MODE_IND     = 3'd0,
    MODE_DISP    = 3'd1,
    MODE_PREDEC  = 3'd2,
    MODE_POSTINC = 3'd3,
    MODE_DIRECT  = 3'd4
  } dagMode_e;

  // strobes from the mode decoder to the address datapath
  typedef struct packed {
    logic useDirect;
    logic addDisp;
    logic preDec;
    logic postInc;
    logic zeroAddr;
    logic wbEn;
  } dagStrobes_t;

endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic [2:0]  modeCode,
  output dagStrobes_t strb
);

  always_comb begin
    strb = '0;
    unique case (modeCode)
      MODE_IND:     ;
      MODE_DISP:    strb.addDisp   = 1'b1;
      MODE_PREDEC:  begin strb.preDec  = 1'b1; strb.wbEn = 1'b1; end
      MODE_POSTINC: begin strb.postInc = 1'b1; strb.wbEn = 1'b1; end
      MODE_DIRECT:  strb.useDirect = 1'b1;
      default:      strb.zeroAddr  = 1'b1;
    endcase
  end

endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DISP_W    = 6,
  parameter int REG_IDX_W = 5,
  parameter int Y_LO_REG  = 28,
  parameter int Z_LO_REG  = 30
) (
  input  dagStrobes_t           strb,
  input  logic                  ptrSel,
  input  logic [DISP_W-1:0]     dispOffset,
  input  logic [2*DATA_W-1:0]   directAddr,
  input  logic [DATA_W-1:0]     yHi,
  input  logic [DATA_W-1:0]     yLo,
  input  logic [DATA_W-1:0]     zHi,
  input  logic [DATA_W-1:0]     zLo,
  output logic [2*DATA_W-1:0]   effAddr,
  output logic                  wbEn,
  output logic [DATA_W-1:0]     wbHi,
  output logic [DATA_W-1:0]     wbLo,
  output logic [REG_IDX_W-1:0]  wbRegHi,
  output logic [REG_IDX_W-1:0]  wbRegLo
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam int PAD_W  = ADDR_W - DISP_W;
  localparam logic [REG_IDX_W-1:0] Y_LO_IDX = REG_IDX_W'(Y_LO_REG);
  localparam logic [REG_IDX_W-1:0] Z_LO_IDX = REG_IDX_W'(Z_LO_REG);

  logic [ADDR_W-1:0] ptrVal;
  logic [ADDR_W-1:0] addrOff;
  logic [ADDR_W-1:0] ptrSum;
  logic [ADDR_W-1:0] ptrNext;
  logic [REG_IDX_W-1:0] loIdx;

  // pointer pair selection
  assign ptrVal = ptrSel ? {zHi, zLo} : {yHi, yLo};
  assign loIdx  = ptrSel ? Z_LO_IDX : Y_LO_IDX;

  // single adder shared by displacement and pre-decrement
  always_comb begin
    if (strb.addDisp)     addrOff = {{PAD_W{1'b0}}, dispOffset};
    else if (strb.preDec) addrOff = '1;
    else                  addrOff = '0;
  end
  assign ptrSum  = ptrVal + addrOff;
  assign ptrNext = strb.preDec ? ptrSum : ptrVal + ADDR_W'(1);

  always_comb begin
    if (strb.useDirect)     effAddr = directAddr;
    else if (strb.zeroAddr) effAddr = '0;
    else                    effAddr = ptrSum;
  end

  assign wbEn    = strb.wbEn;
  assign wbHi    = strb.wbEn ? ptrNext[ADDR_W-1:DATA_W] : '0;
  assign wbLo    = strb.wbEn ? ptrNext[DATA_W-1:0]      : '0;
  assign wbRegLo = strb.wbEn ? loIdx                    : '0;
  assign wbRegHi = strb.wbEn ? loIdx + REG_IDX_W'(1)    : '0;

endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DISP_W    = 6,
  parameter int REG_IDX_W = 5,
  parameter int Y_LO_REG  = 28,
  parameter int Z_LO_REG  = 30
) (
  input  logic [2:0]            modeCode,
  input  logic                  ptrSel,
  input  logic [DISP_W-1:0]     dispOffset,
  input  logic [2*DATA_W-1:0]   directAddr,
  input  logic [DATA_W-1:0]     yHi,
  input  logic [DATA_W-1:0]     yLo,
  input  logic [DATA_W-1:0]     zHi,
  input  logic [DATA_W-1:0]     zLo,
  output logic [2*DATA_W-1:0]   effAddr,
  output logic                  wbEn,
  output logic [DATA_W-1:0]     wbHi,
  output logic [DATA_W-1:0]     wbLo,
  output logic [REG_IDX_W-1:0]  wbRegHi,
  output logic [REG_IDX_W-1:0]  wbRegLo
);

  dagStrobes_t strb;

  dag_ctrl u_ctrl (
    .modeCode (modeCode),
    .strb     (strb)
  );

  dag_datapath #(
    .DATA_W    (DATA_W),
    .DISP_W    (DISP_W),
    .REG_IDX_W (REG_IDX_W),
    .Y_LO_REG  (Y_LO_REG),
    .Z_LO_REG  (Z_LO_REG)
  ) u_dp (
    .strb       (strb),
    .ptrSel     (ptrSel),
    .dispOffset (dispOffset),
    .directAddr (directAddr),
    .yHi        (yHi),
    .yLo        (yLo),
    .zHi        (zHi),
    .zLo        (zLo),
    .effAddr    (effAddr),
    .wbEn       (wbEn),
    .wbHi       (wbHi),
    .wbLo       (wbLo),
    .wbRegHi    (wbRegHi),
    .wbRegLo    (wbRegLo)
  );

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
  parameter int DATA_W    = 8,
  parameter int DISP_W    = 6,
  parameter int REG_IDX_W = 5
) (
  input logic [2:0]            modeCode,
  input logic                  ptrSel,
  input logic [DISP_W-1:0]     dispOffset,
  input logic [2*DATA_W-1:0]   directAddr,
  input logic [DATA_W-1:0]     yHi,
  input logic [DATA_W-1:0]     yLo,
  input logic [DATA_W-1:0]     zHi,
  input logic [DATA_W-1:0]     zLo,
  input logic [2*DATA_W-1:0]   effAddr,
  input logic                  wbEn,
  input logic [DATA_W-1:0]     wbHi,
  input logic [DATA_W-1:0]     wbLo,
  input logic [REG_IDX_W-1:0]  wbRegHi,
  input logic [REG_IDX_W-1:0]  wbRegLo
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] chkPtr;
  logic [ADDR_W-1:0] chkWb;
  assign chkPtr = ptrSel ? {zHi, zLo} : {yHi, yLo};
  assign chkWb  = {wbHi, wbLo};

  always_comb begin
    // R7
    wb_mode_only_chk: assert (!wbEn || modeCode == 3'd2 || modeCode == 3'd3);
    // R7
    wb_quiet_chk: assert (wbEn || (chkWb == '0 && wbRegHi == '0 && wbRegLo == '0));
    // R8
    wb_pair_chk: assert (!wbEn || wbRegHi == wbRegLo + REG_IDX_W'(1));
    if (modeCode == 3'd0) begin
      // R1
      indirect_addr_chk: assert (effAddr == chkPtr);
    end
    if (modeCode == 3'd1) begin
      // R3
      disp_sum_chk: assert (ADDR_W'(effAddr - chkPtr) == ADDR_W'(dispOffset));
    end
    if (modeCode == 3'd2) begin
      // R4
      predec_match_chk: assert (effAddr == chkWb && ADDR_W'(chkPtr - chkWb) == ADDR_W'(1));
    end
    if (modeCode == 3'd3) begin
      // R5
      postinc_step_chk: assert (effAddr == chkPtr && ADDR_W'(chkWb - effAddr) == ADDR_W'(1));
    end
    if (modeCode == 3'd4) begin
      // R6
      direct_pass_chk: assert (effAddr == directAddr);
    end
    if (modeCode > 3'd4) begin
      // R9
      unused_zero_chk: assert (effAddr == '0 && !wbEn);
    end
  end

endmodule

bind dag_top dag_checker #(
  .DATA_W    (DATA_W),
  .DISP_W    (DISP_W),
  .REG_IDX_W (REG_IDX_W)
) u_chk (
  .modeCode   (modeCode),
  .ptrSel     (ptrSel),
  .dispOffset (dispOffset),
  .directAddr (directAddr),
  .yHi        (yHi),
  .yLo        (yLo),
  .zHi        (zHi),
  .zLo        (zLo),
  .effAddr    (effAddr),
  .wbEn       (wbEn),
  .wbHi       (wbHi),
  .wbLo       (wbLo),
  .wbRegHi    (wbRegHi),
  .wbRegLo    (wbRegLo)
);

// File: tb/dag_top_tb.sv
module dag_top_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  modeCode = '0;
  logic        ptrSel = 1'b0;
  logic [5:0]  dispOffset = '0;
  logic [15:0] directAddr = '0;
  logic [7:0]  yHi = '0, yLo = '0, zHi = '0, zLo = '0;
  logic [15:0] effAddr;
  logic        wbEn;
  logic [7:0]  wbHi, wbLo;
  logic [4:0]  wbRegHi, wbRegLo;

  int checks = 0;
  int fails  = 0;

  dag_top u_dut (
    .modeCode (modeCode), .ptrSel (ptrSel), .dispOffset (dispOffset),
    .directAddr (directAddr), .yHi (yHi), .yLo (yLo), .zHi (zHi), .zLo (zLo),
    .effAddr (effAddr), .wbEn (wbEn), .wbHi (wbHi), .wbLo (wbLo),
    .wbRegHi (wbRegHi), .wbRegLo (wbRegLo)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample 1 ns later (well before the rising edge)
  task automatic apply(logic [2:0] m, logic sel, logic [5:0] d, logic [15:0] dir,
                       logic [15:0] y, logic [15:0] z);
    @(negedge clk);
    modeCode = m; ptrSel = sel; dispOffset = d; directAddr = dir;
    {yHi, yLo} = y; {zHi, zLo} = z;
    #1;
  endtask

  task automatic check_wb_off(string req);
    check(req, {31'd0, wbEn}, 32'd0);
    check(req, {16'd0, wbHi, wbLo}, 32'd0);
    check(req, {22'd0, wbRegHi, wbRegLo}, 32'd0);
  endtask

  task automatic t_reset_state;
    apply(3'd0, 1'b0, 6'd0, 16'h0, 16'h0, 16'h0);
    check("R1 idle", {16'd0, effAddr}, 32'h0);
    check_wb_off("R7 idle");
  endtask

  task automatic t_indirect;
    apply(3'd0, 1'b0, 6'd5, 16'hAAAA, 16'h1234, 16'h5678);
    check("R1 indirect Y", {16'd0, effAddr}, 32'h1234);
    check_wb_off("R1 indirect no wb");
    apply(3'd0, 1'b1, 6'd5, 16'hAAAA, 16'h1234, 16'h5678);
    check("R2 indirect Z", {16'd0, effAddr}, 32'h5678);
  endtask

  task automatic t_displacement;
    apply(3'd1, 1'b0, 6'd0, 16'h0, 16'h0100, 16'h0200);
    check("R3 disp 0", {16'd0, effAddr}, 32'h0100);
    apply(3'd1, 1'b1, 6'd63, 16'h0, 16'h0100, 16'h0200);
    check("R3 disp 63 Z", {16'd0, effAddr}, 32'h023F);
    apply(3'd1, 1'b0, 6'd63, 16'h0, 16'hFFF0, 16'h0);
    check("R3 disp wrap", {16'd0, effAddr}, 32'h002F);
    check_wb_off("R7 disp");
  endtask

  task automatic t_predec;
    apply(3'd2, 1'b0, 6'd9, 16'h0, 16'h0300, 16'h7777);
    check("R4 predec addr", {16'd0, effAddr}, 32'h02FF);
    check("R4 predec wb", {16'd0, wbHi, wbLo}, 32'h02FF);
    check("R7 predec en", {31'd0, wbEn}, 32'd1);
    check("R8 predec Y regs", {22'd0, wbRegHi, wbRegLo}, {22'd0, 5'd29, 5'd28});
    apply(3'd2, 1'b1, 6'd0, 16'h0, 16'h1111, 16'h0000);
    check("R4 predec wrap addr", {16'd0, effAddr}, 32'hFFFF);
    check("R4 predec wrap wb", {16'd0, wbHi, wbLo}, 32'hFFFF);
    check("R8 predec Z regs", {22'd0, wbRegHi, wbRegLo}, {22'd0, 5'd31, 5'd30});
  endtask

  task automatic t_postinc;
    apply(3'd3, 1'b1, 6'd0, 16'h0, 16'h4444, 16'h12FF);
    check("R5 postinc addr", {16'd0, effAddr}, 32'h12FF);
    check("R5 postinc wb", {16'd0, wbHi, wbLo}, 32'h1300);
    check("R8 postinc Z regs", {22'd0, wbRegHi, wbRegLo}, {22'd0, 5'd31, 5'd30});
    apply(3'd3, 1'b0, 6'd0, 16'h0, 16'hFFFF, 16'h0);
    check("R5 postinc wrap addr", {16'd0, effAddr}, 32'hFFFF);
    check("R5 postinc wrap wb", {16'd0, wbHi, wbLo}, 32'h0000);
    check("R7 postinc en", {31'd0, wbEn}, 32'd1);
  endtask

  task automatic t_direct;
    apply(3'd4, 1'b0, 6'd63, 16'hBEEF, 16'h1111, 16'h2222);
    check("R6 direct", {16'd0, effAddr}, 32'hBEEF);
    apply(3'd4, 1'b1, 6'd1, 16'hFFFF, 16'h3333, 16'h4444);
    check("R6 direct ignores ptr", {16'd0, effAddr}, 32'hFFFF);
    check_wb_off("R6 direct no wb");
  endtask

  task automatic t_unused;
    for (int m = 5; m < 8; m++) begin
      apply(3'(m), 1'b1, 6'd7, 16'hCAFE, 16'h1234, 16'h5678);
      check("R9 unused addr", {16'd0, effAddr}, 32'h0);
      check_wb_off("R9 unused no wb");
    end
  endtask

  task automatic t_same_cycle;
    apply(3'd0, 1'b0, 6'd0, 16'h0, 16'hABCD, 16'h0);
    @(negedge clk);
    yLo = 8'h01;
    #0.5;
    check("R10 same cycle", {16'd0, effAddr}, 32'hAB01);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_indirect();
    t_displacement();
    t_predec();
    t_postinc();
    t_direct();
    t_unused();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule